// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block holds the control and status logic for a multi-channel analog-to-digital converter. Its one 8-bit register carries an end-of-conversion flag, an interrupt enable, a run bit, a mode bit and a channel select. A host reads and writes the register through a simple strobe port. Conversions start from a software write of the run bit or from either of two timer trigger inputs. The block then drives a channel number and a one-cycle launch pulse to the analog converter, and waits for a done pulse from it.

In single mode one conversion runs on the selected channel. When it finishes, the run bit drops and the end flag rises. In scan mode channels 0 up to the selected channel are converted in ascending order, and the pass repeats without stopping. The end flag rises at the end of every pass. Scanning stops only when software writes 0 to the run bit or reset is applied. The interrupt request is high while both the end flag and the enable are set.

Register layout: bit 7 is the end flag, bit 6 the interrupt enable, bit 5 the run bit, bit 4 reserved, bit 3 the mode (1 = scan), and bits 2:0 the channel select.

Top module: `adc_seq`

## Requirements
- R1: After reset the register reads 0x00, `irq` is 0 and `conv_start` is 0.
- R2: Bit 4 always reads 0, and writing 1 to it changes nothing.
- R3: In single mode (bit 3 = 0), setting the run bit makes `conv_start` high for exactly one cycle, with `conv_chan` equal to bits 2:0. The edge that accepts `conv_done` clears the run bit and sets the end flag.
- R4: In scan mode (bit 3 = 1), conversions run on channels 0, 1, …, sel in order and then repeat from 0. The end flag is set on the edge that accepts the done pulse for channel sel. The run bit stays 1 until software clears it.
- R5: The end flag is cleared only by a write with bit 7 = 0 that comes after a read (strobe `host_rd`) returned the flag as 1. A write of 0 without such a read, or a write of 1, leaves it set.
- R6: If the clearing write and an end-of-conversion event fall in the same cycle, the flag stays set.
- R7: `irq` equals the end flag AND the interrupt enable.
- R8: A pulse on `trig_a` or `trig_b` sets the run bit and starts conversion when the run bit is 0. Either pulse has no effect while conversion is running.
- R9: Writing 0 to the run bit while it is 1 stops the sequencer on the next edge. No further `conv_start` is issued, and a late `conv_done` does not set the flag.
- R10: Bits 3:0 change only through writes made while the run bit is 0.
- R11: A `conv_done` with no conversion outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (arms flag clearing) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Register read value, combinational |
| trig_a | input | 1 | Timer trigger A, start request |
| trig_b | input | 1 | Timer trigger B, start request |
| conv_start | output | 1 | One-cycle launch pulse to the converter |
| conv_chan | output | 3 | Channel being converted |
| conv_done | input | 1 | Conversion complete pulse from the converter |
| irq | output | 1 | Interrupt request |

## Verification
A write or trigger presented in one cycle takes effect at the following edge. The new register value and the launch pulse are therefore visible one cycle after the strobe. A `conv_done` accepted at an edge updates the flag and run bit at that same edge, and the next scan launch appears in the cycle after it. The bench drives every input on the falling edge and samples on a later falling edge. Each check sits at exactly the first falling edge after the register that produces the result.

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       trig_a,
  input  logic       trig_b,
  output logic       conv_start,
  output logic [2:0] conv_chan,
  input  logic       conv_done,
  output logic       irq
);
  localparam int SEL_W = 3;

  logic             flag, ie, go, scan, armed, busy;
  logic [SEL_W-1:0] sel, idx;
  logic             wdata_unused;

  assign wdata_unused = host_wdata[4];

  wire stop    = host_wr & ~host_wdata[5] & go;
  wire launch  = ~go & (host_wr ? host_wdata[5] : (trig_a | trig_b));
  wire accept  = busy & conv_done & ~stop;
  wire last    = ~scan | (idx == sel);
  wire end_evt = accept & last;
  wire clr     = host_wr & ~host_wdata[7] & armed;

  assign conv_start = go & ~busy;
  assign conv_chan  = scan ? idx : sel;
  assign irq        = flag & ie;
  assign host_rdata = {flag, ie, go, 1'b0, scan, sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      ie    <= 1'b0;
      go    <= 1'b0;
      scan  <= 1'b0;
      sel   <= '0;
      armed <= 1'b0;
      busy  <= 1'b0;
      idx   <= '0;
    end else begin
      if (host_wr) ie <= host_wdata[6];
      if (host_wr && !go) {scan, sel} <= host_wdata[3:0];

      if (end_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;

      if (clr)                   armed <= 1'b0;
      else if (host_rd && flag)  armed <= 1'b1;

      if (stop)                  go <= 1'b0;
      else if (end_evt && !scan) go <= 1'b0;
      else if (launch)           go <= 1'b1;

      if (stop)            busy <= 1'b0;
      else if (conv_start) busy <= 1'b1;
      else if (accept)     busy <= 1'b0;

      if (stop || launch) idx <= '0;
      else if (accept)    idx <= last ? '0 : idx + 3'd1;
    end
  end
endmodule

module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       conv_start
);
  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_single_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rdata[7]) && !host_rdata[3]) |-> !host_rdata[5]);

  assert_scan_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[5] && host_rdata[3] && !host_wr) |=> host_rdata[5]);

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[7] && !host_wr) |=> host_rdata[7]);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_wdata[5]) |=> (!conv_start && !host_rdata[5]));

  assert_mode_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[5] |=> (host_rdata[3:0] == $past(host_rdata[3:0])));
endmodule

bind adc_seq adc_seq_chk u_adc_seq_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .conv_start(conv_start)
);

// File: tb/test_adc_seq.sv
`timescale 1ns/1ps
module test_adc_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, trig_a = 1'b0, trig_b = 1'b0, conv_done = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       conv_start, irq;
  logic [2:0] conv_chan;
  logic [7:0] b, rv;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_seq i_adc_seq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .trig_a(trig_a),
    .trig_b(trig_b), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    host_rd = 1'b1; d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic serve(input logic [2:0] ch, input int lat, input string req);
    chk(req, 8'(conv_start), 8'h01);
    chk(req, 8'(conv_chan), 8'(ch));
    @(negedge clk);
    chk(req, 8'(conv_start), 8'h00);
    repeat (lat - 1) @(negedge clk);
    done_pulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset value", host_rdata, 8'h00);
    chk("R1 irq", 8'(irq), 8'h00);
    chk("R1 conv_start", 8'(conv_start), 8'h00);

    wr(8'h10);
    chk("R2 reserved bit", host_rdata, 8'h00);

    done_pulse();
    chk("R11 stray done", host_rdata, 8'h00);
    chk("R11 no launch", 8'(conv_start), 8'h00);

    for (int ie = 0; ie < 2; ie++) begin
      for (int s = 0; s < 8; s++) begin
        b = 8'(ie << 6) | 8'(s);
        wr(b | 8'h20);
        serve(3'(s), 1 + (s % 3), "R3 single launch");
        chk("R3 single end", host_rdata, b | 8'h80);
        chk("R7 irq follows flag and enable", 8'(irq), 8'(ie));
        wr(b);
        chk("R5 write0 without read", 8'(host_rdata[7]), 8'h01);
        rd(rv);
        chk("R5 read value", rv, b | 8'h80);
        wr(b | 8'h80);
        chk("R5 write1 ignored", 8'(host_rdata[7]), 8'h01);
        wr(b);
        chk("R5 armed clear", host_rdata, b);
        chk("R7 irq low", 8'(irq), 8'h00);
      end
    end

    for (int s = 0; s < 8; s++) begin
      b = 8'h08 | 8'(s);
      wr(b | 8'h20);
      for (int pass = 0; pass < 2; pass++) begin
        for (int c = 0; c <= s; c++) begin
          serve(3'(c), 1 + ((c + pass) % 3), "R4 scan order");
          if (c == s) chk("R4 flag at group end", host_rdata, 8'hA8 | 8'(s));
          else chk("R4 mid pass", host_rdata, (pass != 0 ? 8'hA8 : 8'h28) | 8'(s));
        end
      end
      chk("R4 wrap to channel 0", 8'(conv_chan), 8'h00);
      chk("R4 relaunch", 8'(conv_start), 8'h01);
      wr(b);
      chk("R9 stop", host_rdata, 8'h88 | 8'(s));
      chk("R9 no launch", 8'(conv_start), 8'h00);
      done_pulse();
      chk("R9 late done ignored", host_rdata, 8'h88 | 8'(s));
      chk("R9 still idle", 8'(conv_start), 8'h00);
      rd(rv);
      wr(b);
      chk("R5 clear after scan", host_rdata, b);
    end

    wr(8'h2A);
    serve(3'd0, 2, "R10 setup");
    wr(8'h25);
    chk("R10 mode locked", 8'(host_rdata[3:0]), 8'h0A);
    done_pulse();
    chk("R10 sequence kept", 8'(conv_chan), 8'h02);
    wr(8'h0A);
    chk("R9 stop mid scan", host_rdata, 8'h0A);

    wr(8'h03);
    trig_a = 1'b1; @(negedge clk); trig_a = 1'b0;
    serve(3'd3, 2, "R8 trig_a start");
    chk("R8 trig_a result", host_rdata, 8'h83);
    rd(rv); wr(8'h03);
    trig_b = 1'b1; @(negedge clk); trig_b = 1'b0;
    serve(3'd3, 1, "R8 trig_b start");
    chk("R8 trig_b result", host_rdata, 8'h83);
    rd(rv); wr(8'h09);
    chk("R5 clear before trigger scan", host_rdata, 8'h09);

    trig_a = 1'b1; @(negedge clk); trig_a = 1'b0;
    chk("R8 scan launch", 8'(conv_start), 8'h01);
    @(negedge clk);
    trig_b = 1'b1; @(negedge clk); trig_b = 1'b0;
    chk("R8 trigger while running", 8'(conv_start), 8'h00);
    chk("R8 register while running", host_rdata, 8'h29);
    done_pulse();
    chk("R8 no restart", 8'(conv_chan), 8'h01);
    wr(8'h09);
    chk("R9 stop trigger scan", host_rdata, 8'h09);

    wr(8'h22);
    serve(3'd2, 1, "R6 setup");
    chk("R6 setup flag", host_rdata, 8'h82);
    rd(rv);
    wr(8'hA2);
    chk("R6 relaunch keeps flag", host_rdata, 8'hA2);
    @(negedge clk);
    conv_done = 1'b1; host_wr = 1'b1; host_wdata = 8'h22;
    @(negedge clk);
    conv_done = 1'b0; host_wr = 1'b0;
    chk("R6 end beats clear", host_rdata, 8'h82);
    rd(rv); wr(8'h02);
    chk("R6 final clear", host_rdata, 8'h02);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-run actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule